// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches the upper pins of a general-purpose port and raises a sticky change flag when a pin differs from a stored reference copy. Only pins set as inputs take part. The reference copy is reloaded whenever software reads or writes the port. Because of this, a handler must touch the port first and then clear the flag. While a difference remains, the flag sets again on every cycle, so a clear on its own does not stay in effect.

The block takes the synchronized values of the watched pins, their direction bits, a strobe that marks a port access, a strobe that clears the flag, and an interrupt enable. It drives three outputs. The first is the flag itself. The second is an interrupt request, which is the flag qualified by the enable. The third is a wake request, which comes straight from the raw combinational mismatch so that it works while the clock is stopped.

Top module: `pin_change_det`

## Requirements
- R1: A synchronous reset (rstN low at a clock edge) clears changeFlag and loads the reference copy from padIn. After reset, with the pins unchanged, wakeReq is 0 and changeFlag stays 0.
- R2: If any watched input pin differs from its reference bit during a cycle, changeFlag is 1 after the next rising clock edge.
- R3: Each watched pin is compared on its own. A difference on any single one of them (padIn bit 0 or bit 3 alike) sets changeFlag.
- R4: A pin whose direction bit is 0 (output) is left out of the comparison. A pin whose direction bit is 1 is an input. Once the pin is an input again, a difference that is still present counts.
- R5: changeFlag is sticky. It stays 1 after the pin returns to its reference value, until it is cleared.
- R6: If flagClear is applied while a mismatch is still present, changeFlag does not clear, because the set wins.
- R7: A portAccess pulse reloads the reference from padIn and ends the mismatch. A later flagClear then returns changeFlag to 0.
- R8: irqReq is 1 exactly when changeFlag and irqEnable are both 1.
- R9: wakeReq is combinational. It follows the masked mismatch in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| padIn | input | WATCH_W (4) | Synchronized values of the watched upper port pins |
| dirIn | input | WATCH_W (4) | Direction per watched pin, 1 = input |
| portAccess | input | 1 | Port read or write strobe, reloads the reference |
| flagClear | input | 1 | Software clear of the change flag |
| irqEnable | input | 1 | Interrupt enable |
| changeFlag | output | 1 | Sticky change flag |
| irqReq | output | 1 | Flag qualified by the enable |
| wakeReq | output | 1 | Raw mismatch, wake from sleep |

## Verification
A wrong reference copy appears at wakeReq in the same cycle. It shows either as a wake with no pin change or as no wake after a change. It then appears at changeFlag one clock edge later. A flag register that drops or holds wrongly shows one cycle after the clear strobe or after the pin returns. The bench therefore samples wakeReq right after each stimulus, and samples changeFlag and irqReq one edge later.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
  typedef struct packed {
    logic refLoad;
    logic flagSet;
    logic flagDrop;
  } chgCtl_t;
endpackage

// File: rtl/pin_change_dp.sv
module pin_change_dp
  import pin_change_pkg::*;
#(
  parameter int WATCH_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WATCH_W-1:0] padIn,
  input  logic [WATCH_W-1:0] dirIn,
  input  chgCtl_t            ctl,
  output logic               anyMismatch,
  output logic               flagQ
);
  logic [WATCH_W-1:0] refBits;
  logic [WATCH_W-1:0] pinDiff;

  genvar g;
  generate
    for (g = 0; g < WATCH_W; g++) begin : g_pin
      // an output-direction pin never contributes
      assign pinDiff[g] = dirIn[g] & (padIn[g] ^ refBits[g]);
    end
  endgenerate

  assign anyMismatch = |pinDiff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refBits <= padIn;
      flagQ   <= 1'b0;
    end else begin
      if (ctl.refLoad) refBits <= padIn;
      if (ctl.flagSet)       flagQ <= 1'b1;
      else if (ctl.flagDrop) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_change_ctl.sv
module pin_change_ctl
  import pin_change_pkg::*;
(
  input  logic    portAccess,
  input  logic    flagClear,
  input  logic    anyMismatch,
  output chgCtl_t ctl
);
  always_comb begin
    ctl.refLoad  = portAccess;
    ctl.flagSet  = anyMismatch;
    // a pending set overrides a software clear in the same cycle
    ctl.flagDrop = flagClear & ~anyMismatch;
  end
endmodule

// File: rtl/pin_change_det.sv
module pin_change_det
  import pin_change_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int WATCH_LO = 4,
  localparam int WATCH_W = PORT_W - WATCH_LO
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WATCH_W-1:0] padIn,
  input  logic [WATCH_W-1:0] dirIn,
  input  logic               portAccess,
  input  logic               flagClear,
  input  logic               irqEnable,
  output logic               changeFlag,
  output logic               irqReq,
  output logic               wakeReq
);
  chgCtl_t ctl;
  logic    anyMismatch;

  pin_change_ctl u_ctl (
    .portAccess (portAccess),
    .flagClear  (flagClear),
    .anyMismatch(anyMismatch),
    .ctl        (ctl)
  );

  pin_change_dp #(.WATCH_W(WATCH_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .padIn      (padIn),
    .dirIn      (dirIn),
    .ctl        (ctl),
    .anyMismatch(anyMismatch),
    .flagQ      (changeFlag)
  );

  assign wakeReq = anyMismatch;
  assign irqReq  = changeFlag & irqEnable;
endmodule

// File: rtl/pin_change_det_chk.sv
module pin_change_det_chk (
  input logic clk,
  input logic rstN,
  input logic flagClear,
  input logic irqEnable,
  input logic changeFlag,
  input logic irqReq,
  input logic wakeReq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rstN) |-> !changeFlag);

  p_mismatch_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> changeFlag);

  p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(changeFlag) |-> $past(wakeReq));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (changeFlag && !flagClear) |=> changeFlag);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && wakeReq) |=> changeFlag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !wakeReq) |=> !changeFlag);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (changeFlag && irqEnable));

  p_irq_when_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (changeFlag && irqEnable) |-> irqReq);
endmodule

bind pin_change_det pin_change_det_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flagClear (flagClear),
  .irqEnable (irqEnable),
  .changeFlag(changeFlag),
  .irqReq    (irqReq),
  .wakeReq   (wakeReq)
);

// File: tb/pin_change_det_test.sv
`timescale 1ns/1ps
module pin_change_det_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] padIn = 4'hA;
  logic [3:0] dirIn = 4'hF;
  logic       portAccess = 1'b0;
  logic       flagClear = 1'b0;
  logic       irqEnable = 1'b0;
  logic       changeFlag, irqReq, wakeReq;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  pin_change_det uut (
    .clk(clk), .rstN(rstN), .padIn(padIn), .dirIn(dirIn),
    .portAccess(portAccess), .flagClear(flagClear), .irqEnable(irqEnable),
    .changeFlag(changeFlag), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one edge passes between negedges
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic resync();
    portAccess = 1'b1; tick(); portAccess = 1'b0;
    flagClear = 1'b1; tick(); flagClear = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; padIn = 4'hA; tick(); tick();
    padIn = 4'h3; tick();
    rstN = 1'b1; #1;
    check("R1", "wake after reset", wakeReq, 1'b0);
    check("R1", "flag after reset", changeFlag, 1'b0);
    tick(); tick();
    check("R1", "flag stays clear", changeFlag, 1'b0);
  endtask

  task automatic t_changeAndIrq();
    padIn = 4'h2; #1;
    check("R9", "wake same cycle", wakeReq, 1'b1);
    check("R2", "flag before edge", changeFlag, 1'b0);
    tick();
    check("R2", "flag after edge", changeFlag, 1'b1);
    check("R8", "irq disabled", irqReq, 1'b0);
    irqEnable = 1'b1; #1;
    check("R8", "irq enabled", irqReq, 1'b1);
    irqEnable = 1'b0;
    resync();
    check("R7", "flag after access+clear", changeFlag, 1'b0);
  endtask

  task automatic t_sticky();
    padIn = 4'hA; tick();
    padIn = 4'h2; #1;
    check("R9", "wake drops on return", wakeReq, 1'b0);
    tick(); tick();
    check("R5", "flag sticky", changeFlag, 1'b1);
    resync();
  endtask

  task automatic t_setWins();
    padIn = 4'h6; tick();
    flagClear = 1'b1; tick(); flagClear = 1'b0;
    check("R6", "clear with mismatch", changeFlag, 1'b1);
    portAccess = 1'b1; tick(); portAccess = 1'b0; #1;
    check("R7", "wake after access", wakeReq, 1'b0);
    check("R7", "flag before clear", changeFlag, 1'b1);
    flagClear = 1'b1; tick(); flagClear = 1'b0;
    check("R7", "flag cleared", changeFlag, 1'b0);
  endtask

  task automatic t_singlePins();
    padIn = 4'h7; tick();
    check("R3", "pin 0 alone sets", changeFlag, 1'b1);
    resync();
    padIn = 4'hF; tick();
    check("R3", "pin 3 alone sets", changeFlag, 1'b1);
    resync();
  endtask

  task automatic t_outputExcluded();
    dirIn = 4'h7; tick();
    padIn = 4'h7; #1;
    check("R4", "output pin no wake", wakeReq, 1'b0);
    tick(); tick();
    check("R4", "output pin no flag", changeFlag, 1'b0);
    dirIn = 4'hF; #1;
    check("R4", "input again wakes", wakeReq, 1'b1);
    tick();
    check("R4", "input again flags", changeFlag, 1'b1);
    resync();
  endtask

  initial begin
    t_reset();
    t_changeAndIrq();
    t_sticky();
    t_setWins();
    t_singlePins();
    t_outputExcluded();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule